// File: doc/BRIEF.md
# Serial Flash Wake-Up, Identification and Error-Flag Clear Responder

This block is the slave-side command logic of a serial flash device for three operations: clearing the two error flags of the status register, bringing the device out of deep power-down, and returning a one-byte device identifier. The SPI pins (chip select, serial clock, serial input) are brought into the system clock domain. The 8-bit instruction is assembled from SI, MSB first, and decoded. The responder drives SO with the identifier while the read is active. A busy input from the program/erase engine blocks every command. A recovery timer keeps the device deaf to new instructions for a set number of system clock cycles after a wake-up.

The wake/ID instruction (0xAB) has two uses. If chip select rises straight after the opcode, it is a plain wake-up. If three dummy bytes follow the opcode, the identifier is shifted out and repeats until chip select rises. The two cases use different recovery times when they end deep power-down. The flag-clear instruction (0x30) takes effect when chip select rises on a byte boundary.

Top module: `flash_pd_id_resp`

## Requirements
- R1: After reset, so_oe, prog_fail, erase_fail, wel, in_dpd and recovering are all 0.
- R2: Instruction 0x30 (SI sampled on SCLK rising edges, MSB first), ended by a CS# rise after exactly 8 bits, clears prog_fail (status bit 18) and erase_fail (status bit 19). It does this whether wel is 0 or 1 and leaves wel unchanged.
- R3: While wip is 1, instruction 0x30 has no effect on either error flag.
- R4: When pgm_err_set is asserted in the same cycle as a 0x30 clear takes effect, prog_fail ends up 1 and erase_fail is still cleared.
- R5: A dpd_enter pulse sets in_dpd. While in_dpd is 1, every instruction other than 0xAB is ignored.
- R6: 0xAB ended by a CS# rise after exactly 8 bits while in_dpd is 1 clears in_dpd. recovering is then 1 for exactly TRES1_CYC consecutive clock cycles.
- R7: 0xAB followed by three dummy bytes makes the block drive dev_id on SO with so_oe = 1. The bits go out MSB first, each one updated after an SCLK falling edge, and the byte repeats for as long as SCLK runs with CS# low.
- R8: An ID read, as in R7, that ends while in_dpd is 1 clears in_dpd. recovering is then 1 for exactly TRES2_CYC cycles. An ID read outside power-down starts no recovery.
- R9: Any instruction completed while recovering is 1 is discarded.
- R10: While wip is 1, 0xAB is ignored: in_dpd stays set and so_oe stays 0 through any following dummy and data clocks.
- R11: A CS# rise in the middle of an instruction or dummy byte aborts the command with no state change.
- R12: so_oe is 0 while the instruction and dummy bytes shift in, and for the whole of a 0x30 command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock (idles low) |
| si | input | 1 | SPI serial data in |
| so | output | 1 | SPI serial data out, valid when so_oe is 1 |
| so_oe | output | 1 | SO drive enable; 0 means high impedance |
| dev_id | input | ID_W | Identifier returned by the ID read |
| wip | input | 1 | Program/erase/write cycle in progress |
| dpd_enter | input | 1 | One-cycle strobe that enters deep power-down |
| wel_set | input | 1 | Strobe that sets the write-enable latch |
| wel_clr | input | 1 | Strobe that clears the write-enable latch |
| pgm_err_set | input | 1 | Strobe that sets the program-error flag |
| ers_err_set | input | 1 | Strobe that sets the erase-error flag |
| prog_fail | output | 1 | Program-error flag (status bit 18) |
| erase_fail | output | 1 | Erase-error flag (status bit 19) |
| wel | output | 1 | Write-enable latch |
| in_dpd | output | 1 | Device is in deep power-down |
| recovering | output | 1 | Post-wake recovery window is running |

## Verification
The program engine setting an error flag and the 0x30 command clearing it can land in the same system cycle. The bench provokes this by raising CS# at the end of a 0x30 command and pulsing pgm_err_set exactly in the cycle in which the synchronised CS# rise is acted on. It then expects prog_fail to stay 1 while erase_fail clears. A second overlap is a new instruction arriving while the wake-up recovery window is still open. The bench sends 0x30 straight after a wake-up and judges it by the error flags being unchanged. It then repeats the same command once recovering has dropped and expects the flags to clear.

// File: rtl/fpd_pkg.sv
// Package: shared opcodes and command-phase type for the power-down/ID
// responder. Assumes 8-bit instructions sent MSB first.
package fpd_pkg;

    localparam logic [7:0] OP_CLR_FLAGS = 8'h30;
    localparam logic [7:0] OP_WAKE_ID   = 8'hAB;
    localparam int         DUMMY_BYTES  = 3;

    typedef enum logic [2:0] {
        PH_OPCODE,      // collecting the instruction byte
        PH_CLR_ARMED,   // 0x30 accepted, waits for CS# rise on a byte boundary
        PH_DUMMY,       // 0xAB accepted, counting dummy bytes
        PH_ID_OUT,      // shifting the identifier out
        PH_SKIP         // command rejected, ignore until CS# rises
    } phase_e;

endpackage

// File: rtl/fpd_pin_sync.sv
// Module: brings CS#, SCLK and SI into the system clock domain and makes
// single-cycle edge strobes. Assumes the SPI pins change slower than
// (SYNC_STAGES + 1) system clock periods per level.
module fpd_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic si,
    output logic cs_act,
    output logic cs_rise,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic si_b
);
    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] IDLE_PINS = 3'b100; // {cs_n, sclk, si}

    logic [NPIN-1:0] stage [SYNC_STAGES];
    logic [NPIN-1:0] prev;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            // One flop stage of the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage[g] <= IDLE_PINS;
                else if (g == 0)
                    stage[g] <= {cs_n, sclk, si};
                else
                    stage[g] <= stage[g-1];
            end
        end
    endgenerate

    // Holds the previous synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= IDLE_PINS;
        else        prev <= stage[SYNC_STAGES-1];
    end

    // Edge strobes and levels from the last synchroniser stage.
    always_comb begin
        cs_act    = ~stage[SYNC_STAGES-1][2];
        cs_rise   =  stage[SYNC_STAGES-1][2] & ~prev[2];
        sclk_rise =  stage[SYNC_STAGES-1][1] & ~prev[1];
        sclk_fall = ~stage[SYNC_STAGES-1][1] &  prev[1];
        si_b      =  stage[SYNC_STAGES-1][0];
    end

endmodule

// File: rtl/fpd_cmd_fsm.sv
// Module: instruction shifter and decoder. Counts dummy bytes, shifts the
// identifier out, and issues the clear and wake requests when CS# rises.
// Assumes the edge strobes come from fpd_pin_sync and are one cycle wide.
module fpd_cmd_fsm
    import fpd_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_act,
    input  logic            cs_rise,
    input  logic            sclk_rise,
    input  logic            sclk_fall,
    input  logic            si_b,
    input  logic            wip,
    input  logic            in_dpd,
    input  logic            recovering,
    input  logic [ID_W-1:0] dev_id,
    output logic            clr_req,
    output logic            wake_req,
    output logic            wake_long,
    output logic            so,
    output logic            so_oe
);
    localparam int IDX_W = (ID_W > 1) ? $clog2(ID_W) : 1;
    localparam int DCW   = $clog2(DUMMY_BYTES + 1);

    phase_e          phase;
    logic [2:0]      bit_cnt;
    logic [7:0]      shreg;
    logic [7:0]      byte_now;
    logic [DCW-1:0]  dummy_cnt;
    logic [ID_W-1:0] id_hold;
    logic [IDX_W-1:0] out_idx;
    logic            ab_ok;
    logic            clr_ok;
    logic            on_boundary;

    // Acceptance conditions for each instruction at the end of the opcode.
    always_comb begin
        byte_now    = {shreg[6:0], si_b};
        ab_ok       = !wip && !recovering;
        clr_ok      = !wip && !recovering && !in_dpd;
        on_boundary = (bit_cnt == 3'd0);
    end

    // Requests raised when CS# rises at the end of a valid command.
    always_comb begin
        clr_req   = cs_rise && (phase == PH_CLR_ARMED) && on_boundary && !wip;
        wake_req  = cs_rise && in_dpd && !wip &&
                    (((phase == PH_DUMMY) && on_boundary) || (phase == PH_ID_OUT));
        wake_long = (phase == PH_ID_OUT);
    end

    // Command phase, bit/byte counting and identifier shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_OPCODE;
            bit_cnt   <= '0;
            shreg     <= '0;
            dummy_cnt <= '0;
            id_hold   <= '0;
            out_idx   <= '0;
            so        <= 1'b0;
            so_oe     <= 1'b0;
        end else if (cs_rise) begin
            phase     <= PH_OPCODE;
            bit_cnt   <= '0;
            dummy_cnt <= '0;
            out_idx   <= '0;
            so_oe     <= 1'b0;
        end else if (cs_act) begin
            if (sclk_rise) begin
                shreg   <= byte_now;
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    case (phase)
                        PH_OPCODE: begin
                            if (byte_now == OP_WAKE_ID && ab_ok) begin
                                phase     <= PH_DUMMY;
                                dummy_cnt <= '0;
                            end else if (byte_now == OP_CLR_FLAGS && clr_ok) begin
                                phase <= PH_CLR_ARMED;
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                        PH_CLR_ARMED: phase <= PH_SKIP;
                        PH_DUMMY: begin
                            if (dummy_cnt == DCW'(DUMMY_BYTES - 1)) begin
                                phase   <= PH_ID_OUT;
                                id_hold <= dev_id;
                                out_idx <= '0;
                            end else begin
                                dummy_cnt <= dummy_cnt + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            if (sclk_fall && phase == PH_ID_OUT) begin
                so    <= id_hold[IDX_W'(ID_W - 1) - out_idx];
                so_oe <= 1'b1;
                if (out_idx == IDX_W'(ID_W - 1)) out_idx <= '0;
                else                             out_idx <= out_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fpd_recovery_timer.sv
// Module: down-counter that holds off new instructions after a wake-up.
// Loads TRES2_CYC for a wake that ended an ID read, else TRES1_CYC.
module fpd_recovery_timer #(
    parameter int TRES1_CYC = 750,
    parameter int TRES2_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_req,
    input  logic wake_long,
    output logic recovering,
    output logic [$clog2(((TRES1_CYC > TRES2_CYC) ? TRES1_CYC : TRES2_CYC) + 1)-1:0] rec_cnt
);
    localparam int TMAX = (TRES1_CYC > TRES2_CYC) ? TRES1_CYC : TRES2_CYC;
    localparam int CW   = $clog2(TMAX + 1);

    // Load on wake, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rec_cnt <= '0;
        else if (wake_req)
            rec_cnt <= wake_long ? CW'(TRES2_CYC) : CW'(TRES1_CYC);
        else if (rec_cnt != '0)
            rec_cnt <= rec_cnt - 1'b1;
    end

    // Window is open while the counter is non-zero.
    assign recovering = (rec_cnt != '0);

endmodule

// File: rtl/fpd_status_regs.sv
// Module: power-down state, error flags and write-enable latch.
// Set strobes take priority over the command-driven clear.
module fpd_status_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic dpd_enter,
    input  logic wake_req,
    input  logic clr_req,
    input  logic wel_set,
    input  logic wel_clr,
    input  logic pgm_err_set,
    input  logic ers_err_set,
    output logic in_dpd,
    output logic prog_fail,
    output logic erase_fail,
    output logic wel
);
    // Deep power-down state: entry strobe wins over wake.
    always_ff @(posedge clk) begin
        if (!rst_n)         in_dpd <= 1'b0;
        else if (dpd_enter) in_dpd <= 1'b1;
        else if (wake_req)  in_dpd <= 1'b0;
    end

    // Error flags: new error wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_fail  <= 1'b0;
            erase_fail <= 1'b0;
        end else begin
            if (pgm_err_set)  prog_fail  <= 1'b1;
            else if (clr_req) prog_fail  <= 1'b0;
            if (ers_err_set)  erase_fail <= 1'b1;
            else if (clr_req) erase_fail <= 1'b0;
        end
    end

    // Write-enable latch, untouched by the flag clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       wel <= 1'b0;
        else if (wel_set) wel <= 1'b1;
        else if (wel_clr) wel <= 1'b0;
    end

endmodule

// File: rtl/flash_pd_id_resp.sv
// Module: top of the power-down / ID / flag-clear responder.
// Assumes sclk idles low and that wip comes from the program/erase engine.
module flash_pd_id_resp #(
    parameter int ID_W        = 8,
    parameter int TRES1_CYC   = 750,
    parameter int TRES2_CYC   = 1250,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            sclk,
    input  logic            si,
    output logic            so,
    output logic            so_oe,
    input  logic [ID_W-1:0] dev_id,
    input  logic            wip,
    input  logic            dpd_enter,
    input  logic            wel_set,
    input  logic            wel_clr,
    input  logic            pgm_err_set,
    input  logic            ers_err_set,
    output logic            prog_fail,
    output logic            erase_fail,
    output logic            wel,
    output logic            in_dpd,
    output logic            recovering
);
    localparam int TMAX = (TRES1_CYC > TRES2_CYC) ? TRES1_CYC : TRES2_CYC;
    localparam int CW   = $clog2(TMAX + 1);

    logic          cs_act, cs_rise, sclk_rise, sclk_fall, si_b;
    logic          clr_req, wake_req, wake_long;
    logic [CW-1:0] rec_cnt;

    fpd_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
        .cs_act(cs_act), .cs_rise(cs_rise), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .si_b(si_b)
    );

    fpd_cmd_fsm #(.ID_W(ID_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_rise(cs_rise),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .si_b(si_b),
        .wip(wip), .in_dpd(in_dpd), .recovering(recovering), .dev_id(dev_id),
        .clr_req(clr_req), .wake_req(wake_req), .wake_long(wake_long),
        .so(so), .so_oe(so_oe)
    );

    fpd_recovery_timer #(.TRES1_CYC(TRES1_CYC), .TRES2_CYC(TRES2_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .wake_long(wake_long),
        .recovering(recovering), .rec_cnt(rec_cnt)
    );

    fpd_status_regs u_stat (
        .clk(clk), .rst_n(rst_n), .dpd_enter(dpd_enter), .wake_req(wake_req),
        .clr_req(clr_req), .wel_set(wel_set), .wel_clr(wel_clr),
        .pgm_err_set(pgm_err_set), .ers_err_set(ers_err_set),
        .in_dpd(in_dpd), .prog_fail(prog_fail), .erase_fail(erase_fail), .wel(wel)
    );

endmodule

// File: rtl/fpd_checker.sv
// Checker: temporal properties of the responder, bound into the top module.
module fpd_checker #(
    parameter int TRES1_CYC = 750,
    parameter int TRES2_CYC = 1250,
    parameter int CW        = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wip,
    input logic          dpd_enter,
    input logic          wel_set,
    input logic          wel_clr,
    input logic          pgm_err_set,
    input logic          clr_req,
    input logic          wake_req,
    input logic          prog_fail,
    input logic          erase_fail,
    input logic          wel,
    input logic          in_dpd,
    input logic          recovering,
    input logic [CW-1:0] rec_cnt
);
    p_clear_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erase_fail) |-> !$past(wip));

    p_clear_keeps_wel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !wel_set && !wel_clr) |=> (wel == $past(wel)));

    p_set_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_err_set |=> prog_fail);

    p_wake_leaves_dpd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(recovering) && !$past(dpd_enter)) |-> (!in_dpd && $past(in_dpd)));

    p_recovery_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recovering) |-> (rec_cnt == CW'(TRES1_CYC) || rec_cnt == CW'(TRES2_CYC)));

    p_window_counts_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (recovering && !wake_req) |=> (rec_cnt == $past(rec_cnt) - 1'b1));

endmodule

bind flash_pd_id_resp fpd_checker #(
    .TRES1_CYC(TRES1_CYC), .TRES2_CYC(TRES2_CYC), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wip(wip), .dpd_enter(dpd_enter),
    .wel_set(wel_set), .wel_clr(wel_clr), .pgm_err_set(pgm_err_set),
    .clr_req(clr_req), .wake_req(wake_req), .prog_fail(prog_fail),
    .erase_fail(erase_fail), .wel(wel), .in_dpd(in_dpd),
    .recovering(recovering), .rec_cnt(rec_cnt)
);

// File: tb/tb_flash_pd_id_resp.sv
`timescale 1ns/1ps
module tb_flash_pd_id_resp;
    localparam int T1   = 300;
    localparam int T2   = 500;
    localparam int HALF = 8;   // system clocks per SCLK half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, si = 1'b0;
    logic so, so_oe;
    logic [7:0] dev_id = 8'hC5;
    logic wip = 1'b0, dpd_enter = 1'b0, wel_set = 1'b0, wel_clr = 1'b0;
    logic pgm_err_set = 1'b0, ers_err_set = 1'b0;
    logic prog_fail, erase_fail, wel, in_dpd, recovering;

    int n_chk = 0;
    int n_bad = 0;
    logic oe_seen = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    flash_pd_id_resp #(.ID_W(8), .TRES1_CYC(T1), .TRES2_CYC(T2)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
        .so(so), .so_oe(so_oe), .dev_id(dev_id), .wip(wip),
        .dpd_enter(dpd_enter), .wel_set(wel_set), .wel_clr(wel_clr),
        .pgm_err_set(pgm_err_set), .ers_err_set(ers_err_set),
        .prog_fail(prog_fail), .erase_fail(erase_fail), .wel(wel),
        .in_dpd(in_dpd), .recovering(recovering)
    );

    always @(negedge clk) if (so_oe) oe_seen = 1'b1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic strobe(ref logic s);
        s = 1'b1; tick(1); s = 1'b0; tick(1);
    endtask

    task automatic spi_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            si = b[i]; tick(HALF);
            sclk = 1'b1; tick(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic spi_read(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            tick(HALF);
            b[i] = so;
            sclk = 1'b1; tick(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0; tick(HALF);
    endtask

    task automatic cs_high_settle();
        tick(HALF); cs_n = 1'b1; tick(8);
    endtask

    task automatic set_errors();
        strobe(pgm_err_set); strobe(ers_err_set);
    endtask

    task automatic send_cmd(input logic [7:0] op);
        cs_low(); spi_bits(op, 8); cs_high_settle();
    endtask

    // Counts the length of the recovery window that starts after CS# rises.
    task automatic measure_rec(input int exp, input string req);
        int len = 0;
        int waitc = 0;
        while (!recovering && waitc < 30) begin tick(1); waitc++; end
        while (recovering && len < 5000) begin tick(1); len++; end
        chk(len == exp, req, len, exp);
    endtask

    task automatic wait_ready();
        int c = 0;
        while (recovering && c < 5000) begin tick(1); c++; end
        tick(4);
    endtask

    task automatic t_reset();
        chk(so_oe == 0 && prog_fail == 0 && erase_fail == 0, "R1 oe/flags", 
            {so_oe, prog_fail, erase_fail}, 0);
        chk(wel == 0 && in_dpd == 0 && recovering == 0, "R1 wel/dpd/rec",
            {wel, in_dpd, recovering}, 0);
    endtask

    task automatic t_clear_flags();
        set_errors();
        strobe(wel_set);
        oe_seen = 1'b0;
        send_cmd(8'h30);
        chk(prog_fail == 0 && erase_fail == 0, "R2 flags cleared wel=1",
            {prog_fail, erase_fail}, 0);
        chk(wel == 1, "R2 wel unchanged", wel, 1);
        chk(oe_seen == 0, "R12 no drive on 0x30", oe_seen, 0);
        strobe(wel_clr);
        set_errors();
        send_cmd(8'h30);
        chk(prog_fail == 0 && erase_fail == 0 && wel == 0, "R2 clear with wel=0",
            {prog_fail, erase_fail, wel}, 0);
    endtask

    task automatic t_clear_busy();
        set_errors();
        wip = 1'b1;
        send_cmd(8'h30);
        chk(prog_fail == 1 && erase_fail == 1, "R3 ignored while busy",
            {prog_fail, erase_fail}, 3);
        wip = 1'b0;
        send_cmd(8'h30);
    endtask

    task automatic t_set_vs_clear();
        set_errors();
        cs_low(); spi_bits(8'h30, 8); tick(HALF);
        cs_n = 1'b1;             // cs_rise is acted on at the third posedge
        tick(2);
        pgm_err_set = 1'b1; tick(1); pgm_err_set = 1'b0;
        tick(6);
        chk(prog_fail == 1, "R4 set wins over clear", prog_fail, 1);
        chk(erase_fail == 0, "R4 clear still applied", erase_fail, 0);
        send_cmd(8'h30);
    endtask

    task automatic t_dpd_blocks();
        strobe(dpd_enter);
        chk(in_dpd == 1, "R5 dpd entered", in_dpd, 1);
        set_errors();
        send_cmd(8'h30);
        chk(prog_fail == 1 && erase_fail == 1 && in_dpd == 1, "R5 0x30 ignored in dpd",
            {prog_fail, erase_fail, in_dpd}, 7);
    endtask

    task automatic t_wake_short();
        cs_low(); spi_bits(8'hAB, 8); tick(HALF);
        cs_n = 1'b1;
        measure_rec(T1, "R6 tRES1 length");
        chk(in_dpd == 0, "R6 left dpd", in_dpd, 0);
        tick(8);
    endtask

    task automatic t_recovery_discard();
        // flags still set from t_dpd_blocks
        strobe(dpd_enter);
        cs_low(); spi_bits(8'hAB, 8); tick(HALF);
        cs_n = 1'b1; tick(4);
        send_cmd(8'h30);
        chk(recovering == 1, "R9 still in window", recovering, 1);
        chk(prog_fail == 1 && erase_fail == 1, "R9 0x30 discarded",
            {prog_fail, erase_fail}, 3);
        wait_ready();
        send_cmd(8'h30);
        chk(prog_fail == 0 && erase_fail == 0, "R9 accepted after window",
            {prog_fail, erase_fail}, 0);
    endtask

    task automatic t_id_read(input logic [7:0] id);
        logic [7:0] b0, b1;
        dev_id = id;
        oe_seen = 1'b0;
        cs_low(); spi_bits(8'hAB, 8);
        for (int d = 0; d < 3; d++) spi_bits(8'h00, 8);
        chk(oe_seen == 0, "R12 quiet during instr/dummy", oe_seen, 0);
        spi_read(b0); spi_read(b1);
        chk(b0 == id, "R7 first id byte", b0, id);
        chk(b1 == id, "R7 repeated id byte", b1, id);
        chk(so_oe == 1, "R7 so driven", so_oe, 1);
        cs_high_settle();
        chk(so_oe == 0 && recovering == 0, "R8 no recovery outside dpd",
            {so_oe, recovering}, 0);
    endtask

    task automatic t_id_wake();
        logic [7:0] b0;
        dev_id = 8'h3A;
        strobe(dpd_enter);
        cs_low(); spi_bits(8'hAB, 8);
        for (int d = 0; d < 3; d++) spi_bits(8'h00, 8);
        spi_read(b0);
        chk(b0 == 8'h3A, "R8 id read in dpd", b0, 8'h3A);
        tick(HALF); cs_n = 1'b1;
        measure_rec(T2, "R8 tRES2 length");
        chk(in_dpd == 0, "R8 left dpd", in_dpd, 0);
        tick(8);
    endtask

    task automatic t_ab_busy();
        logic [7:0] b0;
        strobe(dpd_enter);
        wip = 1'b1;
        oe_seen = 1'b0;
        cs_low(); spi_bits(8'hAB, 8);
        for (int d = 0; d < 3; d++) spi_bits(8'h00, 8);
        spi_read(b0);
        cs_high_settle();
        tick(10);
        chk(oe_seen == 0, "R10 no id while busy", oe_seen, 0);
        chk(in_dpd == 1 && recovering == 0, "R10 stays in dpd",
            {in_dpd, recovering}, 2);
        wip = 1'b0;
    endtask

    task automatic t_abort();
        // still in dpd: partial 0xAB must not wake
        cs_low(); spi_bits(8'hAB, 5); cs_high_settle();
        tick(10);
        chk(in_dpd == 1 && recovering == 0, "R11 partial wake aborted",
            {in_dpd, recovering}, 2);
        send_cmd(8'hAB);
        wait_ready();
        set_errors();
        cs_low(); spi_bits(8'h30, 8); spi_bits(8'h00, 3); cs_high_settle();
        chk(prog_fail == 1 && erase_fail == 1, "R11 overlong 0x30 aborted",
            {prog_fail, erase_fail}, 3);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_clear_flags();
        t_clear_busy();
        t_set_vs_clear();
        t_dpd_blocks();
        t_wake_short();
        t_dpd_blocks();
        t_recovery_discard();
        t_id_read(8'hC5);
        t_id_read(8'h81);
        t_id_wake();
        t_ab_busy();
        t_abort();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule